// File: doc/BRIEF.md
# Fail-Safe Mode Supervisor with Threshold Lockout

This block sits beside the power-mode controller of a bus transceiver. It watches a fault input. When fail-safe handling is enabled, a fault moves the block from the operating mode into a low-power fail-safe mode. The block records a three-bit reason code, raises an interrupt flag and starts an inactivity timer that runs on an external tick. The block returns to the operating mode only after the fault has cleared and a bus or local wake pulse then arrives. If the timer runs out first, the block drops to sleep.

Software can enable a running count of fail-safe entries. The count is only cleared by software, so "consecutive" means "since the last clear", with no time window. When the count reaches a programmed threshold, the block carries out a programmed action. One action forces sleep and locks out every wake until a power-on reset. Another action forces sleep but keeps wakes working.

Configuration and status sit in three byte-wide registers behind a simple write strobe and a combinational read port. Every control and status pin is a plain level or one-cycle pulse. There is no stream interface, so no valid/ready handshake applies.

Top module: `fsafe_supervisor`

## Requirements
- R1: After reset, `mode_o` is 0 (operating), `irq_o` is 0, and registers 0x17, 0x18 and 0x53 read 0x00. The mode encoding is 0 operating, 1 fail-safe, 2 sleep.
- R2: In operating mode with register 0x17 bit 0 clear, a high `fault_i` sampled at a clock edge moves `mode_o` to 1 after that edge. The same edge sets `irq_o`, sets register 0x53 bit 5, and stores `fault_code_i` into register 0x17 bits 3:1.
- R3: With register 0x17 bit 0 set, `fault_i` has no effect: `mode_o` stays 0 and `irq_o` stays 0.
- R4: In fail-safe mode, a wake pulse (`bus_wake_i` or `local_wake_i`) seen while `fault_i` is high is ignored. A wake pulse seen while `fault_i` is low returns `mode_o` to 0. A wake wins over a timeout in the same cycle.
- R5: After `TIMEOUT_TICKS` cycles with `tick_i` high during fail-safe mode, `mode_o` becomes 2. The tick count restarts from zero at every fail-safe entry.
- R6: In sleep mode without lockout, a wake pulse while `fault_i` is low moves `mode_o` to 0. A high `fault_i` in sleep mode changes nothing.
- R7: Register 0x17 bit 7 enables the entry count in register 0x18 bits 3:0. Each entry adds one, and the count saturates at 15. With the bit clear, entries are not counted. Register 0x18 bits 7:4 hold the threshold. A write to 0x18 whose bits 3:0 are zero clears the count; other values of those bits are ignored.
- R8: With register 0x17 bits 6:4 = 001, an entry that brings the count to at least a nonzero threshold goes straight to sleep (`mode_o` = 2). From then on, wakes, faults and register writes cannot leave sleep; only `rst_n` does.
- R9: With action 010, a threshold-reaching entry goes straight to sleep and `irq_o` is set, but wakes still work. Action 000, the reserved codes 011 to 111, and a threshold of 0 all give the normal fail-safe entry.
- R10: Writing 0x53 with bit 5 set clears `irq_o`. If an entry happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| fault_i | input | 1 | Fault present (level) |
| fault_code_i | input | 3 | Reason code for the fault |
| bus_wake_i | input | 1 | Bus wake pulse |
| local_wake_i | input | 1 | Local wake pulse |
| tick_i | input | 1 | Inactivity timer tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Fail-safe entry interrupt flag |
| mode_o | output | 2 | Current mode (0 operating, 1 fail-safe, 2 sleep) |

## Verification
The bench targets these corner cases:
- A wake that arrives while the fault is still present. A design that honours it returns to operating mode early.
- A second fail-safe entry after an earlier partial tick count. A timer that is not restarted at entry reaches sleep one tick too soon.
- Saturation of the entry count at 15, where a wrapping counter would read back 0.
- A threshold of zero, and a reserved action code, which a careless decoder would treat as a trigger.
- The lockout, checked against every wake source and against a counter clear. It must hold until reset.
- An interrupt clear written in the same cycle as an entry, where a design with the wrong priority loses the flag.

// File: rtl/fsafe_pkg.sv
package fsafe_pkg;

  typedef enum logic [1:0] {
    MODE_OPER  = 2'd0,
    MODE_FSAFE = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  localparam logic [2:0] ACT_NONE  = 3'd0;
  localparam logic [2:0] ACT_LOCK  = 3'd1;
  localparam logic [2:0] ACT_SLEEP = 3'd2;

  // Field layout of the configuration register
  typedef struct packed {
    logic       cnt_en;
    logic [2:0] action;
    logic [2:0] reason;
    logic       fs_dis;
  } cfg_t;

endpackage

// File: rtl/fsafe_timer.sv
module fsafe_timer #(
  parameter int TIMEOUT_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (start_i)                    cnt_q <= '0;
    else if (run_i && tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == '0));

  // R5
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));
endmodule

// File: rtl/fsafe_evcnt.sv
module fsafe_evcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             entry_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;

  assign nxt   = (cnt_q == MAXV) ? MAXV : CNT_W'(cnt_q + 1'b1);
  assign hit_o = en_i && (thr_i != '0) && (nxt >= thr_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (entry_i && en_i) cnt_q <= nxt;
  end

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr_i) |=> (cnt_q == MAXV));

  // R7
  no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fsafe_regs.sv
module fsafe_regs
  import fsafe_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter int          CNT_W    = 4,
  parameter logic [7:0]  CFG_ADDR = 8'h17,
  parameter logic [7:0]  CNT_ADDR = 8'h18,
  parameter logic [7:0]  INT_ADDR = 8'h53,
  parameter int          INT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              entry_i,
  input  logic [2:0]        reason_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic              cnt_clr_o,
  output logic              irq_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] thr_q;
  logic             irq_q;
  logic             wr_cfg, wr_cnt, wr_int;
  cfg_t             wcfg;

  assign wr_cfg = reg_wr_i && (reg_addr_i == ADDR_W'(CFG_ADDR));
  assign wr_cnt = reg_wr_i && (reg_addr_i == ADDR_W'(CNT_ADDR));
  assign wr_int = reg_wr_i && (reg_addr_i == ADDR_W'(INT_ADDR));
  assign wcfg   = cfg_t'(reg_wdata_i[7:0]);

  assign cnt_clr_o = wr_cnt && (reg_wdata_i[CNT_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      thr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q.fs_dis <= wcfg.fs_dis;
        cfg_q.action <= wcfg.action;
        cfg_q.cnt_en <= wcfg.cnt_en;
      end
      if (entry_i) cfg_q.reason <= reason_i;
      if (wr_cnt)  thr_q <= reg_wdata_i[2*CNT_W-1:CNT_W];
      if (entry_i)                          irq_q <= 1'b1;
      else if (wr_int && reg_wdata_i[INT_BIT]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CFG_ADDR))      reg_rdata_o[7:0] = cfg_q;
    else if (reg_addr_i == ADDR_W'(CNT_ADDR)) reg_rdata_o[2*CNT_W-1:0] = {thr_q, cnt_i};
    else if (reg_addr_i == ADDR_W'(INT_ADDR)) reg_rdata_o[INT_BIT] = irq_q;
  end

  assign cfg_o = cfg_q;
  assign thr_o = thr_q;
  assign irq_o = irq_q;

  // R10
  entry_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> irq_q);

  // R2
  reason_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> (cfg_q.reason == $past(reason_i)));
endmodule

// File: rtl/fsafe_ctrl.sv
module fsafe_ctrl
  import fsafe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_i,
  input  logic       fs_en_i,
  input  logic       wake_i,
  input  logic       timeout_i,
  input  logic       hit_i,
  input  logic [2:0] action_i,
  output mode_e      mode_o,
  output logic       entry_o
);
  mode_e mode_q, mode_d;
  logic  locked_q, locked_d;
  logic  wake_ok;

  assign wake_ok = wake_i && !fault_i;
  assign entry_o = (mode_q == MODE_OPER) && fault_i && fs_en_i && !locked_q;

  always_comb begin
    mode_d   = mode_q;
    locked_d = locked_q;
    unique case (mode_q)
      MODE_OPER: begin
        if (entry_o) begin
          if (hit_i && action_i == ACT_LOCK) begin
            mode_d   = MODE_SLEEP;
            locked_d = 1'b1;
          end else if (hit_i && action_i == ACT_SLEEP) begin
            mode_d = MODE_SLEEP;
          end else begin
            mode_d = MODE_FSAFE;
          end
        end
      end
      MODE_FSAFE: begin
        if (wake_ok)        mode_d = MODE_OPER;
        else if (timeout_i) mode_d = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (!locked_q && wake_ok) mode_d = MODE_OPER;
      end
      default: mode_d = MODE_OPER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_OPER;
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked_d;
    end
  end

  assign mode_o = mode_q;

  // R4
  fault_blocks_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FSAFE && fault_i) |=> (mode_q != MODE_OPER));

  // R8
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> (locked_q && mode_q == MODE_SLEEP));

  // R3
  disabled_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OPER && !fs_en_i) |=> (mode_q == MODE_OPER));
endmodule

// File: rtl/fsafe_supervisor.sv
module fsafe_supervisor
  import fsafe_pkg::*;
#(
  parameter int         TIMEOUT_TICKS = 8,
  parameter int         ADDR_W        = 8,
  parameter int         DATA_W        = 8,
  parameter int         CNT_W         = 4,
  parameter logic [7:0] CFG_ADDR      = 8'h17,
  parameter logic [7:0] CNT_ADDR      = 8'h18,
  parameter logic [7:0] INT_ADDR      = 8'h53,
  parameter int         INT_BIT       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic [2:0]        fault_code_i,
  input  logic              bus_wake_i,
  input  logic              local_wake_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [1:0]        mode_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] thr, cnt;
  logic             cnt_clr, entry, hit, expire;
  mode_e            mode;

  fsafe_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CFG_ADDR(CFG_ADDR), .CNT_ADDR(CNT_ADDR), .INT_ADDR(INT_ADDR), .INT_BIT(INT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .entry_i(entry), .reason_i(fault_code_i), .cnt_i(cnt),
    .cfg_o(cfg), .thr_o(thr), .cnt_clr_o(cnt_clr), .irq_o(irq_o)
  );

  fsafe_evcnt #(.CNT_W(CNT_W)) u_evcnt (
    .clk(clk), .rst_n(rst_n), .en_i(cfg.cnt_en), .clr_i(cnt_clr),
    .entry_i(entry), .thr_i(thr), .cnt_o(cnt), .hit_o(hit)
  );

  fsafe_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(entry),
    .run_i(mode == MODE_FSAFE), .tick_i(tick_i), .expire_o(expire)
  );

  fsafe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .fs_en_i(!cfg.fs_dis),
    .wake_i(bus_wake_i || local_wake_i), .timeout_i(expire),
    .hit_i(hit), .action_i(cfg.action), .mode_o(mode), .entry_o(entry)
  );

  assign mode_o = mode;
endmodule

// File: tb/fsafe_supervisor_bench.sv
`timescale 1ns/1ps
module fsafe_supervisor_bench;
  localparam int TO = 4;
  localparam int NV = 17;
  // {fault, code[2:0], bus_wake, local_wake, tick, expected mode[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    9'b1_101_0_0_0_01, 9'b1_101_1_0_0_01, 9'b1_101_0_0_1_01, 9'b0_000_0_1_0_00,
    9'b0_000_0_0_0_00, 9'b1_010_0_0_0_01, 9'b1_010_0_0_1_01, 9'b1_010_0_0_1_01,
    9'b1_010_0_0_1_01, 9'b1_010_0_0_1_10, 9'b1_010_1_0_0_10, 9'b0_000_1_0_0_00,
    9'b1_011_0_0_0_01, 9'b0_011_0_0_1_01, 9'b0_011_0_0_1_01, 9'b0_011_0_0_1_01,
    9'b0_011_0_1_1_00
  };

  logic clk = 0, rst_n = 0;
  logic fault = 0, bw = 0, lw = 0, tk = 0, wr = 0;
  logic [2:0] code = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic irq;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fsafe_supervisor #(.TIMEOUT_TICKS(TO)) u_fsafe_supervisor (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .fault_code_i(code),
    .bus_wake_i(bw), .local_wake_i(lw), .tick_i(tk),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .mode_o(mode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic [2:0] c, input logic b, input logic l, input logic t);
    fault = f; code = c; bw = b; lw = l; tk = t;
    @(posedge clk); @(negedge clk);
    bw = 0; lw = 0; tk = 0; wr = 0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #0.1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", {6'd0, mode}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rchk("R1 cfg", 8'h17, 8'h00);
    rchk("R1 cnt", 8'h18, 8'h00);
    rchk("R1 int", 8'h53, 8'h00);

    // R2 R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R2/R4/R5/R6 row %0d", i), {6'd0, mode}, {6'd0, VEC[i][1:0]});
    end
    chk("R2 irq", {7'd0, irq}, 8'd1);
    rchk("R2 reason", 8'h17, 8'h06);
    rchk("R2 int reg", 8'h53, 8'h20);
    wreg(8'h53, 8'h20);
    chk("R10 clear", {7'd0, irq}, 8'd0);

    // R3 disabled
    wreg(8'h17, 8'h01);
    step(1, 3'd4, 0, 0, 0);
    chk("R3 mode", {6'd0, mode}, 8'd0);
    chk("R3 irq", {7'd0, irq}, 8'd0);
    step(0, 0, 0, 0, 0);
    wreg(8'h17, 8'h00);

    // R10 set wins over clear in same cycle
    wr = 1; addr = 8'h53; wdata = 8'h20;
    step(1, 3'd1, 0, 0, 0);
    chk("R10 same cycle irq", {7'd0, irq}, 8'd1);
    step(0, 0, 1, 0, 0);
    wreg(8'h53, 8'h20);

    // R7 counting, saturation, threshold zero
    wreg(8'h17, 8'h80);
    wreg(8'h18, 8'h00);
    for (int n = 0; n < 17; n++) begin
      step(1, 3'd1, 0, 0, 0);
      chk("R9 thr0 fail-safe", {6'd0, mode}, 8'd1);
      step(0, 0, 1, 0, 0);
      if (n == 0) rchk("R7 count one", 8'h18, 8'h01);
    end
    rchk("R7 saturate", 8'h18, 8'h0F);
    wreg(8'h18, 8'h05);
    rchk("R7 nonzero write ignored", 8'h18, 8'h0F);
    wreg(8'h18, 8'h00);
    rchk("R7 clear", 8'h18, 8'h00);
    wreg(8'h17, 8'h00);
    step(1, 3'd1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    rchk("R7 disabled no count", 8'h18, 8'h00);

    // R9 action sleep, wakes still work
    wreg(8'h53, 8'h20);
    wreg(8'h17, 8'hA0);
    wreg(8'h18, 8'h20);
    step(1, 3'd2, 0, 0, 0);
    chk("R9 below thr", {6'd0, mode}, 8'd1);
    step(0, 0, 1, 0, 0);
    wreg(8'h53, 8'h20);
    step(1, 3'd2, 0, 0, 0);
    chk("R9 forced sleep", {6'd0, mode}, 8'd2);
    chk("R9 irq", {7'd0, irq}, 8'd1);
    step(0, 0, 1, 0, 0);
    chk("R9 wake works", {6'd0, mode}, 8'd0);
    rchk("R9 count", 8'h18, 8'h22);

    // R9 reserved action behaves as none
    wreg(8'h17, 8'hF0);
    wreg(8'h18, 8'h10);
    step(1, 3'd2, 0, 0, 0);
    chk("R9 reserved action", {6'd0, mode}, 8'd1);
    step(0, 0, 1, 0, 0);

    // R8 lockout
    wreg(8'h17, 8'h90);
    wreg(8'h18, 8'h10);
    step(1, 3'd6, 0, 0, 0);
    chk("R8 lock sleep", {6'd0, mode}, 8'd2);
    step(0, 0, 1, 0, 0);
    chk("R8 bus wake ignored", {6'd0, mode}, 8'd2);
    step(0, 0, 0, 1, 0);
    chk("R8 local wake ignored", {6'd0, mode}, 8'd2);
    wreg(8'h18, 8'h00);
    step(0, 0, 1, 1, 1);
    chk("R8 after clear", {6'd0, mode}, 8'd2);
    step(1, 3'd1, 0, 0, 0);
    chk("R8 fault ignored", {6'd0, mode}, 8'd2);
    step(0, 0, 0, 0, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset releases", {6'd0, mode}, 8'd0);
    rchk("R1 cfg after reset", 8'h17, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule